// File: doc/BRIEF.md
# BCD Calendar Clock with Transfer Freeze

This block is a time-of-day and calendar core stepped by a 100 Hz tick pulse. It counts hundredths, seconds, minutes, hours, weekday, date, month and year in BCD. Hours run in either 24-hour or 12-hour-with-PM format. The month length follows the calendar, and February gains a day in every year divisible by four.

Two copies of the time are kept. A running copy is advanced on every enabled tick. A visible copy is what the byte-wide register port returns. The visible copy is reloaded from the running copy on each tick unless software has frozen it through the control register. Software can then read a consistent snapshot while no time is lost.

A time-of-day alarm compares minutes, hours and weekday at each minute boundary. Each field has its own mask. A match sets a sticky flag, which any read or write of an alarm register clears. Software reads and writes registers with a single-cycle strobe. The read data is a combinational function of the address.

Top module: `bcd_rtc`

## Requirements
- R1: After reset the registers read: hundredths 0x00, seconds 0x00, minutes 0x00, hours 0x00 (24-hour), weekday 0x01, date 0x01, month 0x01, year 0x00, the three alarm registers 0x00, control 0x80, and `alarm_flag` is low.
- R2: Each enabled tick advances hundredths (address 0) in BCD from 00 to 99. The 99-to-00 wrap advances seconds (address 1, 00..59), which in turn carries into minutes (address 2, 00..59).
- R3: In 24-hour mode (hours register, address 3, bit 6 = 0, BCD 00..23 in bits 5:0), the hour increments at each minute carry. 23 wraps to 00 and advances the day.
- R4: In 12-hour mode (bit 6 = 1, bit 5 = PM, BCD 01..12 in bits 4:0), 11 goes to 12 with PM toggled, and 12 goes to 01 with PM unchanged. The day advances only on 11 PM to 12 AM.
- R5: On a day carry, the date (address 5) wraps to 01 after 31, 30, 28 or 29 days, as the month (address 6, 01..12) requires. February has 29 days when the BCD year (address 7) is divisible by four. Month 12 wraps to 01 and increments the year, and year 99 wraps to 00.
- R6: Weekday (address 4) counts 1..7 and wraps from 7 to 1 on each day carry.
- R7: While control (address 11) bit 7 is 0, ticks leave the readable registers unchanged but the running copy keeps counting. After bit 7 returns to 1, the first tick makes the readable registers show the running time.
- R8: A write to a time register (addresses 0..7) loads both copies. A value written while frozen is therefore read back at once, and counting continues from it after transfers resume.
- R9: When month bit 7 is 1, ticks are ignored by both copies. Month bits 7 and 6 read back as written.
- R10: The alarm registers are minutes (address 8), hours (address 9) and weekday (address 10), each with bit 7 as a mask. The alarm event occurs on the tick where seconds roll from 59 to 00. It requires every unmasked field to equal the new time. Masking the weekday gives a daily alarm, masking weekday and hour gives an hourly one, and masking all three fires every minute.
- R11: An alarm event sets `alarm_flag` and control bit 0. The flag stays set until a read or write strobe to address 8, 9 or 10 clears it. Access to other addresses does not clear it.
- R12: Bits with no meaning read 0 whatever is written. These are seconds, minutes and hours bit 7, weekday bits 7:3, date bits 7:6, month bit 5, alarm weekday bits 6:3, and control bits 6:1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One-cycle pulse every 10 ms |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (marks an access for alarm clearing) |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr`, combinational |
| alarm_flag | output | 1 | Sticky time-of-day alarm flag |

## Verification
The counting chain is swept tick by tick across more than a full minute from a cleared time. Every hour value is then tried in both hour formats from 23:59:59.99-style boundaries, which separates the 12-hour PM toggle and its single day carry from the plain 24-hour wrap. Month ends are driven for every month in leap, common and century-wrap years, one day before and on the last day, which exposes a wrong day table or leap test. The freeze, the write-while-frozen and the oscillator-stop tests each compare the readable registers before and after ticks, so they distinguish a stalled running copy from a stalled visible copy. The alarm cases pair matching and near-miss times under each mask set.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int RTC_AW = 4;
  localparam int RTC_DW = 8;

  typedef logic [RTC_DW-1:0] bcd_t;

  typedef struct packed {
    bcd_t hund;
    bcd_t sec;
    bcd_t min;
    bcd_t hour;
    bcd_t wday;
    bcd_t date;
    bcd_t month;
    bcd_t year;
  } rtc_time_t;

  localparam logic [RTC_AW-1:0] A_HUND  = 4'h0;
  localparam logic [RTC_AW-1:0] A_SEC   = 4'h1;
  localparam logic [RTC_AW-1:0] A_MIN   = 4'h2;
  localparam logic [RTC_AW-1:0] A_HOUR  = 4'h3;
  localparam logic [RTC_AW-1:0] A_WDAY  = 4'h4;
  localparam logic [RTC_AW-1:0] A_DATE  = 4'h5;
  localparam logic [RTC_AW-1:0] A_MONTH = 4'h6;
  localparam logic [RTC_AW-1:0] A_YEAR  = 4'h7;
  localparam logic [RTC_AW-1:0] A_AMIN  = 4'h8;
  localparam logic [RTC_AW-1:0] A_AHOUR = 4'h9;
  localparam logic [RTC_AW-1:0] A_ADAY  = 4'hA;
  localparam logic [RTC_AW-1:0] A_CTRL  = 4'hB;

  localparam rtc_time_t RTC_RESET = '{hund: 8'h00, sec: 8'h00, min: 8'h00,
                                      hour: 8'h00, wday: 8'h01, date: 8'h01,
                                      month: 8'h01, year: 8'h00};

  function automatic bcd_t bcd_add1(input bcd_t v);
    if (v[3:0] == 4'd9) return {v[7:4] + 4'd1, 4'd0};
    return v + 8'd1;
  endfunction

  function automatic bcd_t bcd2bin(input bcd_t v);
    return ({4'd0, v[7:4]} * 8'd10) + {4'd0, v[3:0]};
  endfunction

  function automatic bcd_t month_len(input bcd_t month, input bcd_t year);
    bcd_t yb;
    yb = bcd2bin(year);
    case (month)
      8'h02: return (yb[1:0] == 2'b00) ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default: return 8'h31;
    endcase
  endfunction

  // Returns {day_carry, next_hour_byte}
  function automatic logic [RTC_DW:0] hour_step(input bcd_t h);
    bcd_t n;
    bcd_t t;
    logic c;
    n = h;
    c = 1'b0;
    if (h[6]) begin
      if (h[4:0] == 5'h12) begin
        n[4:0] = 5'h01;
      end else if (h[4:0] == 5'h11) begin
        n[4:0] = 5'h12;
        n[5]   = ~h[5];
        c      = h[5];
      end else begin
        t = bcd_add1({3'd0, h[4:0]});
        n[4:0] = t[4:0];
      end
    end else begin
      if (h[5:0] == 6'h23) begin
        n[5:0] = 6'h00;
        c      = 1'b1;
      end else begin
        t = bcd_add1({2'd0, h[5:0]});
        n[5:0] = t[5:0];
      end
    end
    n[7] = 1'b0;
    return {c, n};
  endfunction

  function automatic rtc_time_t put_field(input rtc_time_t t,
                                          input logic [RTC_AW-1:0] a,
                                          input bcd_t d);
    rtc_time_t r;
    r = t;
    case (a)
      A_HUND:  r.hund  = d;
      A_SEC:   r.sec   = d & 8'h7F;
      A_MIN:   r.min   = d & 8'h7F;
      A_HOUR:  r.hour  = d & 8'h7F;
      A_WDAY:  r.wday  = d & 8'h07;
      A_DATE:  r.date  = d & 8'h3F;
      A_MONTH: r.month = d & 8'h1F;
      A_YEAR:  r.year  = d;
      default: ;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/rtc_chain.sv
module rtc_chain
  import rtc_pkg::*;
(
  input  rtc_time_t cur,
  output rtc_time_t nxt,
  output logic      sec_roll
);
  logic c_hund, c_sec, c_min, c_hour, c_date;
  logic last_day;
  logic [RTC_DW:0] hs;

  always_comb begin
    nxt      = cur;
    hs       = hour_step(cur.hour);
    last_day = (cur.date == month_len(cur.month, cur.year));

    c_hund   = (cur.hund == 8'h99);
    nxt.hund = c_hund ? 8'h00 : bcd_add1(cur.hund);

    c_sec = c_hund && (cur.sec == 8'h59);
    if (c_hund) nxt.sec = (cur.sec == 8'h59) ? 8'h00 : bcd_add1(cur.sec);

    c_min = c_sec && (cur.min == 8'h59);
    if (c_sec) nxt.min = (cur.min == 8'h59) ? 8'h00 : bcd_add1(cur.min);

    c_hour = c_min && hs[RTC_DW];
    if (c_min) nxt.hour = hs[RTC_DW-1:0];

    if (c_hour) begin
      nxt.wday = (cur.wday == 8'h07) ? 8'h01 : bcd_add1(cur.wday);
      nxt.date = last_day ? 8'h01 : bcd_add1(cur.date);
    end
    c_date = c_hour && last_day;

    if (c_date) begin
      nxt.month = (cur.month == 8'h12) ? 8'h01 : bcd_add1(cur.month);
      if (cur.month == 8'h12)
        nxt.year = (cur.year == 8'h99) ? 8'h00 : bcd_add1(cur.year);
    end

    sec_roll = c_sec;
  end
endmodule

// File: rtl/rtc_alarm.sv
module rtc_alarm
  import rtc_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic evt,
  input  bcd_t cur_min,
  input  bcd_t cur_hour,
  input  bcd_t cur_wday,
  input  bcd_t alm_min,
  input  bcd_t alm_hour,
  input  bcd_t alm_day,
  input  logic clr,
  output logic fire,
  output logic flag
);
  logic hit_min, hit_hour, hit_day;

  always_comb begin
    hit_min  = alm_min[7]  || ((alm_min  & 8'h7F) == cur_min);
    hit_hour = alm_hour[7] || ((alm_hour & 8'h7F) == cur_hour);
    hit_day  = alm_day[7]  || ((alm_day  & 8'h07) == cur_wday);
    fire     = evt && hit_min && hit_hour && hit_day;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     flag <= 1'b0;
    else if (fire)  flag <= 1'b1;
    else if (clr)   flag <= 1'b0;
  end
endmodule

// File: rtl/bcd_rtc.sv
module bcd_rtc
  import rtc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [RTC_AW-1:0] reg_addr,
  input  logic [RTC_DW-1:0] reg_wdata,
  output logic [RTC_DW-1:0] reg_rdata,
  output logic              alarm_flag
);
  rtc_time_t int_q, ext_q, nxt, int_d, ext_d;
  logic osc_off_q, sqw_off_q, xfer_q;
  bcd_t alm_min_q, alm_hour_q, alm_day_q;

  // named events for the checker
  logic step, sec_roll, fire, alarm_acc, wr_time, wr_hund;
  bcd_t int_hund, ext_hund;

  assign step      = tick && !osc_off_q;
  assign wr_time   = reg_wr && (reg_addr <= A_YEAR);
  assign wr_hund   = reg_wr && (reg_addr == A_HUND);
  assign alarm_acc = (reg_wr || reg_rd) &&
                     (reg_addr == A_AMIN || reg_addr == A_AHOUR || reg_addr == A_ADAY);
  assign int_hund  = int_q.hund;
  assign ext_hund  = ext_q.hund;

  rtc_chain u_chain (
    .cur      (int_q),
    .nxt      (nxt),
    .sec_roll (sec_roll)
  );

  rtc_alarm u_alarm (
    .clk      (clk),
    .rst_n    (rst_n),
    .evt      (step && sec_roll),
    .cur_min  (nxt.min),
    .cur_hour (nxt.hour),
    .cur_wday (nxt.wday),
    .alm_min  (alm_min_q),
    .alm_hour (alm_hour_q),
    .alm_day  (alm_day_q),
    .clr      (alarm_acc),
    .fire     (fire),
    .flag     (alarm_flag)
  );

  always_comb begin
    int_d = step ? nxt : int_q;
    ext_d = (step && xfer_q) ? nxt : ext_q;
    if (wr_time) begin
      int_d = put_field(int_d, reg_addr, reg_wdata);
      ext_d = put_field(ext_d, reg_addr, reg_wdata);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      int_q      <= RTC_RESET;
      ext_q      <= RTC_RESET;
      osc_off_q  <= 1'b0;
      sqw_off_q  <= 1'b0;
      xfer_q     <= 1'b1;
      alm_min_q  <= '0;
      alm_hour_q <= '0;
      alm_day_q  <= '0;
    end else begin
      int_q <= int_d;
      ext_q <= ext_d;
      if (reg_wr) begin
        case (reg_addr)
          A_MONTH: begin
            osc_off_q <= reg_wdata[7];
            sqw_off_q <= reg_wdata[6];
          end
          A_CTRL:  xfer_q     <= reg_wdata[7];
          A_AMIN:  alm_min_q  <= reg_wdata;
          A_AHOUR: alm_hour_q <= reg_wdata;
          A_ADAY:  alm_day_q  <= reg_wdata & 8'h87;
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    case (reg_addr)
      A_HUND:  reg_rdata = ext_q.hund;
      A_SEC:   reg_rdata = ext_q.sec;
      A_MIN:   reg_rdata = ext_q.min;
      A_HOUR:  reg_rdata = ext_q.hour;
      A_WDAY:  reg_rdata = ext_q.wday;
      A_DATE:  reg_rdata = ext_q.date;
      A_MONTH: reg_rdata = ext_q.month | {osc_off_q, sqw_off_q, 6'd0};
      A_YEAR:  reg_rdata = ext_q.year;
      A_AMIN:  reg_rdata = alm_min_q;
      A_AHOUR: reg_rdata = alm_hour_q;
      A_ADAY:  reg_rdata = alm_day_q;
      A_CTRL:  reg_rdata = {xfer_q, 6'd0, alarm_flag};
      default: reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/bcd_rtc_chk.sv
module bcd_rtc_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       step,
  input logic       sec_roll,
  input logic       fire,
  input logic       alarm_acc,
  input logic       alarm_flag,
  input logic       xfer_en,
  input logic       osc_off,
  input logic       wr_hund,
  input logic [7:0] int_hund,
  input logic [7:0] ext_hund
);
  // R7: frozen visible copy holds unless written
  a_r7_frozen_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!xfer_en && !wr_hund) |=> $stable(ext_hund));

  // R9: stopped oscillator holds the running copy
  a_r9_stopped_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (osc_off && !wr_hund) |=> $stable(int_hund));

  // R2: hundredths wrap from 99 to 00
  a_r2_hund_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (step && int_hund == 8'h99 && !wr_hund) |=> (int_hund == 8'h00));

  // R10: the alarm only fires on an enabled tick at a seconds rollover
  a_r10_fire_at_roll: assert property (@(posedge clk) disable iff (!rst_n)
    fire |-> (step && sec_roll));

  // R10: flag rises only after a fire event
  a_r10_flag_source: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(alarm_flag) |-> $past(fire));

  // R11: access to an alarm register clears the flag
  a_r11_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (alarm_acc && !fire) |=> !alarm_flag);

  // R11: flag is sticky without an alarm access
  a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (alarm_flag && !alarm_acc) |=> alarm_flag);
endmodule

bind bcd_rtc bcd_rtc_chk chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .step       (step),
  .sec_roll   (sec_roll),
  .fire       (fire),
  .alarm_acc  (alarm_acc),
  .alarm_flag (alarm_flag),
  .xfer_en    (xfer_q),
  .osc_off    (osc_off_q),
  .wr_hund    (wr_hund),
  .int_hund   (int_hund),
  .ext_hund   (ext_hund)
);

// File: tb/bcd_rtc_tb_top.sv
`timescale 1ns/1ps
module bcd_rtc_tb_top;
  localparam logic [3:0] HU = 4'h0, SE = 4'h1, MI = 4'h2, HO = 4'h3, WD = 4'h4,
                         DT = 4'h5, MO = 4'h6, YR = 4'h7, AM = 4'h8, AH = 4'h9,
                         AD = 4'hA, CT = 4'hB;

  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0, reg_wr = 1'b0, reg_rd = 1'b0;
  logic [3:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  wire  [7:0] reg_rdata;
  wire        alarm_flag;
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  bcd_rtc dut_i (.clk(clk), .rst_n(rst_n), .tick(tick), .reg_wr(reg_wr),
                 .reg_rd(reg_rd), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
                 .reg_rdata(reg_rdata), .alarm_flag(alarm_flag));

  always #4 clk = ~clk;

  function automatic logic [7:0] to_bcd(input int v);
    return 8'((v / 10) * 16 + (v % 10));
  endfunction

  function automatic int mdays(input int m, input int y);
    if (m == 2) return (y % 4 == 0) ? 29 : 28;
    if (m == 4 || m == 6 || m == 9 || m == 11) return 30;
    return 31;
  endfunction

  task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd_strobe(input logic [3:0] a);
    @(negedge clk); reg_addr = a; reg_rd = 1'b1;
    @(negedge clk); reg_rd = 1'b0;
  endtask

  task automatic look(input logic [3:0] a, output logic [7:0] v);
    @(negedge clk); reg_addr = a; #1 v = reg_rdata;
  endtask

  task automatic ticks(input int n);
    @(negedge clk); tick = 1'b1;
    repeat (n) @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic set_clock(input logic [7:0] h, input int m, input int s, input int hu);
    wr(HO, h); wr(MI, to_bcd(m)); wr(SE, to_bcd(s)); wr(HU, to_bcd(hu));
  endtask

  task automatic set_date(input int w, input int d, input int m, input int y);
    wr(WD, to_bcd(w)); wr(DT, to_bcd(d)); wr(MO, to_bcd(m)); wr(YR, to_bcd(y));
  endtask

  task automatic expect_reg(input string tag, input logic [3:0] a, input logic [7:0] e);
    logic [7:0] v;
    look(a, v);
    check(tag, v, e);
  endtask

  task automatic alarm_case(input string tag, input logic [7:0] am, input logic [7:0] ah,
                            input logic [7:0] ad, input int w, input logic [7:0] h,
                            input int m, input int s, input logic exp);
    wr(AM, am); wr(AH, ah); wr(AD, ad);
    set_date(w, 1, 1, 24);
    set_clock(h, m, s, 99);
    ticks(1);
    check(tag, {7'd0, alarm_flag}, {7'd0, exp});
    expect_reg(tag, CT, {7'h40, exp});
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_run();
    end
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset values
    expect_reg("R1", HU, 8'h00); expect_reg("R1", SE, 8'h00);
    expect_reg("R1", MI, 8'h00); expect_reg("R1", HO, 8'h00);
    expect_reg("R1", WD, 8'h01); expect_reg("R1", DT, 8'h01);
    expect_reg("R1", MO, 8'h01); expect_reg("R1", YR, 8'h00);
    expect_reg("R1", AM, 8'h00); expect_reg("R1", AH, 8'h00);
    expect_reg("R1", AD, 8'h00); expect_reg("R1", CT, 8'h80);
    check("R1", {7'd0, alarm_flag}, 8'h00);

    // R12 unused bits read zero
    wr(SE, 8'hFF); expect_reg("R12", SE, 8'h7F);
    wr(MI, 8'hFF); expect_reg("R12", MI, 8'h7F);
    wr(HO, 8'hFF); expect_reg("R12", HO, 8'h7F);
    wr(WD, 8'hFF); expect_reg("R12", WD, 8'h07);
    wr(DT, 8'hFF); expect_reg("R12", DT, 8'h3F);
    wr(MO, 8'hFF); expect_reg("R12", MO, 8'hDF);
    wr(AD, 8'hFF); expect_reg("R12", AD, 8'h87);
    wr(CT, 8'hFF); expect_reg("R12", CT, 8'h80);
    wr(AD, 8'h00);

    // R2 tick-by-tick sweep over more than a minute
    set_date(1, 1, 1, 0);
    set_clock(8'h00, 0, 0, 0);
    for (int n = 1; n <= 6100; n++) begin
      ticks(1);
      expect_reg("R2", HU, to_bcd(n % 100));
      expect_reg("R2", SE, to_bcd((n / 100) % 60));
      expect_reg("R2", MI, to_bcd(n / 6000));
    end

    // R3 24-hour sweep
    for (int h = 0; h < 24; h++) begin
      set_date(1, 15, 6, 24);
      set_clock(to_bcd(h), 59, 59, 99);
      ticks(1);
      expect_reg("R3", HO, to_bcd((h + 1) % 24));
      expect_reg("R3", MI, 8'h00);
      expect_reg("R3", DT, (h == 23) ? 8'h16 : 8'h15);
    end

    // R4 12-hour sweep
    for (int pm = 0; pm < 2; pm++) begin
      for (int h = 1; h <= 12; h++) begin
        int nh, npm;
        nh  = (h == 12) ? 1 : h + 1;
        npm = (h == 11) ? 1 - pm : pm;
        set_date(1, 15, 6, 24);
        set_clock(8'h40 | 8'(pm * 32) | to_bcd(h), 59, 59, 99);
        ticks(1);
        expect_reg("R4", HO, 8'h40 | 8'(npm * 32) | to_bcd(nh));
        expect_reg("R4", DT, (h == 11 && pm == 1) ? 8'h16 : 8'h15);
      end
    end

    // R6 weekday wrap
    for (int w = 1; w <= 7; w++) begin
      set_date(w, 10, 3, 24);
      set_clock(8'h23, 59, 59, 99);
      ticks(1);
      expect_reg("R6", WD, to_bcd(w % 7 + 1));
    end

    // R5 month ends across leap, common and wrapping years
    for (int yi = 0; yi < 4; yi++) begin
      int y;
      y = (yi == 0) ? 0 : (yi == 1) ? 23 : (yi == 2) ? 24 : 99;
      for (int m = 1; m <= 12; m++) begin
        for (int k = 0; k < 2; k++) begin
          int dl;
          dl = mdays(m, y);
          set_date(2, dl - 1 + k, m, y);
          set_clock(8'h23, 59, 59, 99);
          ticks(1);
          if (k == 0) begin
            expect_reg("R5", DT, to_bcd(dl));
            expect_reg("R5", MO, to_bcd(m));
          end else begin
            expect_reg("R5", DT, 8'h01);
            expect_reg("R5", MO, to_bcd(m == 12 ? 1 : m + 1));
            expect_reg("R5", YR, to_bcd(m == 12 ? (y + 1) % 100 : y));
          end
        end
      end
    end

    // R7 freeze
    set_date(1, 1, 1, 0);
    set_clock(8'h00, 0, 0, 0);
    wr(CT, 8'h00);
    ticks(250);
    expect_reg("R7", HU, 8'h00);
    expect_reg("R7", SE, 8'h00);
    wr(CT, 8'h80);
    expect_reg("R7", HU, 8'h00);
    ticks(1);
    expect_reg("R7", HU, 8'h51);
    expect_reg("R7", SE, 8'h02);

    // R8 write while frozen
    set_clock(8'h00, 0, 0, 0);
    wr(CT, 8'h00);
    ticks(30);
    wr(SE, 8'h30);
    expect_reg("R8", SE, 8'h30);
    expect_reg("R8", HU, 8'h00);
    ticks(100);
    expect_reg("R8", SE, 8'h30);
    wr(CT, 8'h80);
    ticks(1);
    expect_reg("R8", SE, 8'h31);
    expect_reg("R8", HU, 8'h31);

    // R9 oscillator stop
    set_clock(8'h00, 0, 0, 0);
    wr(MO, 8'h81);
    ticks(50);
    expect_reg("R9", HU, 8'h00);
    expect_reg("R9", MO, 8'h81);
    wr(MO, 8'h41);
    expect_reg("R9", MO, 8'h41);
    ticks(1);
    expect_reg("R9", HU, 8'h01);
    wr(MO, 8'h01);

    // R10 alarm masks
    alarm_case("R10 full match",    8'h05, 8'h10, 8'h03, 3, 8'h10, 4, 59, 1'b1);
    alarm_case("R10 day miss",      8'h05, 8'h10, 8'h03, 4, 8'h10, 4, 59, 1'b0);
    alarm_case("R10 hour miss",     8'h05, 8'h10, 8'h03, 3, 8'h09, 4, 59, 1'b0);
    alarm_case("R10 no roll",       8'h05, 8'h10, 8'h03, 3, 8'h10, 4, 58, 1'b0);
    alarm_case("R10 daily",         8'h05, 8'h10, 8'h80, 4, 8'h10, 4, 59, 1'b1);
    alarm_case("R10 hourly",        8'h05, 8'h90, 8'h80, 4, 8'h11, 4, 59, 1'b1);
    alarm_case("R10 hourly miss",   8'h05, 8'h90, 8'h80, 4, 8'h11, 5, 59, 1'b0);
    alarm_case("R10 minute miss",   8'h80, 8'h80, 8'h80, 2, 8'h07, 33, 58, 1'b0);
    alarm_case("R10 every minute",  8'h80, 8'h80, 8'h80, 2, 8'h07, 33, 59, 1'b1);

    // R11 sticky flag and clearing
    ticks(120);
    check("R11 hold", {7'd0, alarm_flag}, 8'h01);
    rd_strobe(SE);
    check("R11 other access", {7'd0, alarm_flag}, 8'h01);
    rd_strobe(AH);
    check("R11 read clear", {7'd0, alarm_flag}, 8'h00);
    expect_reg("R11", CT, 8'h80);
    ticks(50);
    check("R11 stays clear", {7'd0, alarm_flag}, 8'h00);
    set_clock(8'h07, 40, 59, 99);
    ticks(1);
    check("R11 set again", {7'd0, alarm_flag}, 8'h01);
    wr(AD, 8'h80);
    check("R11 write clear", {7'd0, alarm_flag}, 8'h00);

    done = 1'b1;
    finish_run();
  end
endmodule